// File: doc/BRIEF.md
# Two-Wire Controlled Dual Wiper Potentiometer Controller

This block is the digital front end of a 256-step digital potentiometer with one or two channels. It is a slave on a two-wire serial bus. It oversamples SCL and SDA with the system clock and pulls SDA low through an open-drain enable. Each channel has an 8-bit wiper latch that drives the resistor ladder, which lies outside this block. The block also drives two general-purpose logic outputs and a pair of switch controls per channel. One switch control opens the A terminal and the other shorts the wiper to B.

A write starts with the device address, which carries the direction bit. The next byte is a command byte, and any bytes after it are wiper data. Every data byte in the same write goes to the channel that the command chose. A read needs no command byte. It returns the wiper of the channel named by the most recent command and keeps sending bytes until the master stops acknowledging. The master may issue a repeated START between the command byte and the read.

Parameters set the number of channels (`NUM_CH`), the glitch-filter length in clock cycles (`FILT_LEN`), the fixed upper address bits and the midscale code.

Top module: `dual_wiper_i2c`

## Requirements
- R1: The slave address is `{5'b01011, addr_strap[1], addr_strap[0]}` and is followed by the R/W bit (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch SDA stays released and the rest of the transfer has no effect.
- R2: The first byte after a write address is the command. Its fields are: bit 7 selects the channel (0 = `wiper0`, 1 = `wiper1`); bit 6 requests midscale; bit 5 is soft shutdown; bit 4 goes to `gpo[1]`; bit 3 goes to `gpo[0]`. Bits 2..0 are ignored. The command byte is acknowledged.
- R3: When command bit 6 is set, the selected wiper latch is loaded with 8'h80.
- R4: Each data byte after the command in the same write replaces the selected wiper latch and is acknowledged. A data byte never changes the other channel.
- R5: A read returns the wiper of the channel named by the last command, MSB first. The block sends another byte after each master acknowledge. After a master not-acknowledge it releases SDA.
- R6: After reset both wiper latches hold 8'h80, `gpo` is 0, soft shutdown is off and SDA is released.
- R7: Shutdown is active while `shdn_n` is low or the soft shutdown bit is set. While it is active, `a_open` and `w_to_b` are 1 for every channel. The wiper latches keep their values through shutdown and after it ends.
- R8: A write made of only the address and the command updates `gpo` and the soft shutdown bit. It leaves both wipers unchanged unless bit 6 requests midscale.
- R9: The block changes SDA only while SCL is low. A START or STOP at any point returns the block to address reception and releases SDA, and a partly received byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus |
| sda_oe | output | 1 | When 1, pull SDA low |
| addr_strap | input | 2 | Strapped low address bits |
| shdn_n | input | 1 | Active-low hardware shutdown |
| wiper0 | output | 8 | Wiper latch of channel 1 |
| wiper1 | output | 8 | Wiper latch of channel 2 |
| gpo | output | 2 | General-purpose logic outputs |
| a_open | output | NUM_CH | Open the A terminal, per channel |
| w_to_b | output | NUM_CH | Short the wiper to B, per channel |

## Verification
The bench builds the block with `NUM_CH` = 2 and `FILT_LEN` = 3. With two channels, the bench can test channel selection, repeated data bytes landing on the second wiper, and readback that follows the last command. The short filter lets a bit period of 48 clocks carry many random transactions and still keep the synchronizer and filter delay inside each SCL low phase. The single-channel build, in which bit 7 is forced to channel 1, is not built by this bench.

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c #(
  parameter int          NUM_CH     = 2,
  parameter int          FILT_LEN   = 3,
  parameter logic [4:0]  DEV_PREFIX = 5'b01011,
  parameter logic [7:0]  MID_CODE   = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_strap,
  input  logic              shdn_n,
  output logic [7:0]        wiper0,
  output logic [7:0]        wiper1,
  output logic [1:0]        gpo,
  output logic [NUM_CH-1:0] a_open,
  output logic [NUM_CH-1:0] w_to_b
);
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_RD} st_t;

  logic [1:0] raw, flt, flt_q;
  assign raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      logic m1, m2, f;
      logic [FW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          m1 <= 1'b1; m2 <= 1'b1; f <= 1'b1; cnt <= '0;
        end else begin
          m1 <= raw[g];
          m2 <= m1;
          if (m2 != f) begin
            if (cnt == FW'(FILT_LEN - 1)) begin
              f   <= m2;
              cnt <= '0;
            end else cnt <= cnt + FW'(1);
          end else cnt <= '0;
        end
      assign flt[g] = f;
    end
  endgenerate

  logic scl, sda, scl_q, sda_q;
  assign {scl, sda}     = flt;
  assign {scl_q, sda_q} = flt_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, rdbyte;
  logic       rw, nack, sel, sd_bit;
  logic [7:0] wip [2];

  logic       addr_hit, csel;
  logic [7:0] cur;
  assign addr_hit = shreg[7:1] == {DEV_PREFIX, addr_strap};
  assign csel     = (NUM_CH > 1) ? shreg[7] : 1'b0;
  assign cur      = wip[sel];
  assign wiper0   = wip[0];
  assign wiper1   = wip[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q  <= 2'b11;
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      rdbyte <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sel    <= 1'b0;
      sd_bit <= 1'b0;
      gpo    <= '0;
      sda_oe <= 1'b0;
      wip[0] <= MID_CODE;
      wip[1] <= MID_CODE;
    end else begin
      flt_q <= flt;
      if (start_c) begin
        st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda};
          else               nack  <= sda;
        end
        if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              S_ADDR: if (addr_hit) begin sda_oe <= 1'b1; rw <= shreg[0]; end
                      else st <= S_IDLE;
              S_CMD: begin
                sel    <= csel;
                if (shreg[6]) wip[csel] <= MID_CODE;
                sd_bit <= shreg[5];
                gpo    <= shreg[4:3];
                sda_oe <= 1'b1;
              end
              S_WR:    begin wip[sel] <= shreg; sda_oe <= 1'b1; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            case (st)
              S_ADDR:
                if (rw) begin st <= S_RD; rdbyte <= cur; sda_oe <= ~cur[7]; end
                else    begin st <= S_CMD; sda_oe <= 1'b0; end
              S_RD:
                if (nack) begin st <= S_IDLE; sda_oe <= 1'b0; end
                else      begin rdbyte <= cur; sda_oe <= ~cur[7]; end
              default: begin st <= S_WR; sda_oe <= 1'b0; end
            endcase
          end else if (st == S_RD && bitcnt != 4'd0) begin
            sda_oe <= ~rdbyte[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end

  logic sd_all;
  assign sd_all = ~shdn_n | sd_bit;
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign a_open[c] = sd_all;
      assign w_to_b[c] = sd_all;
    end
  endgenerate

  a_r1_nack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && scl_fall && bitcnt == 4'd8 && !addr_hit) |=> !sda_oe);
  a_r4_wiper_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> ($stable(wiper0) && $stable(wiper1)));
  a_r8_gpo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(gpo));
  a_r9_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  a_r9_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
endmodule

// File: tb/test_dual_wiper_i2c.sv
`timescale 1ns/1ps
module test_dual_wiper_i2c;
  localparam int Q = 12;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, shdn_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic [7:0] wiper0, wiper1;
  logic [1:0] gpo, a_open, w_to_b;
  wire sda_bus = sda_m & ~sda_oe;

  dual_wiper_i2c #(.NUM_CH(2), .FILT_LEN(3)) i_dual_wiper_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .shdn_n(shdn_n), .wiper0(wiper0), .wiper1(wiper1),
    .gpo(gpo), .a_open(a_open), .w_to_b(w_to_b));

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_w [2];
  logic [1:0] m_gpo;
  logic m_sd, m_sel;
  logic [6:0] dev;

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic check_state(input string r);
    logic sd;
    sd = m_sd | ~shdn_n;
    chk({r, " wiper0"}, wiper0, m_w[0]);
    chk({r, " wiper1"}, wiper1, m_w[1]);
    chk({r, " gpo"}, gpo, m_gpo);
    chk({r, " a_open"}, a_open, {2{sd}});
    chk({r, " w_to_b"}, w_to_b, {2{sd}});
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = ~sda_bus; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1'b1; wt(Q); b = {b[6:0], sda_bus}; wt(Q); scl_m = 1'b0;
    end
    wt(Q);
    sda_m = ~mack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] cmd, input int nd,
                    input bit do_stop, input string r);
    logic ack;
    logic [7:0] d;
    start_c();
    put_byte({a, 1'b0}, ack);
    chk({r, " R1 address ack"}, ack, a == dev);
    if (a != dev) begin
      put_byte(cmd, ack);
      chk({r, " R1 no ack after mismatch"}, ack, 0);
      stop_c(); check_state({r, " R1 ignored"});
      return;
    end
    put_byte(cmd, ack);
    chk({r, " R2 command ack"}, ack, 1);
    m_sel = cmd[7];
    if (cmd[6]) m_w[m_sel] = 8'h80;
    m_sd = cmd[5];
    m_gpo = cmd[4:3];
    for (int i = 0; i < nd; i++) begin
      d = 8'($urandom);
      put_byte(d, ack);
      chk({r, " R4 data ack"}, ack, 1);
      m_w[m_sel] = d;
    end
    if (do_stop) stop_c();
    check_state(r);
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string r);
    logic ack;
    logic [7:0] b;
    start_c();
    put_byte({a, 1'b1}, ack);
    chk({r, " R1 read address ack"}, ack, a == dev);
    if (a == dev)
      for (int i = 0; i < n; i++) begin
        get_byte(i != n - 1, b);
        chk({r, " R5 read data"}, b, m_w[m_sel]);
      end
    chk({r, " R5 SDA released"}, sda_bus, 1);
    stop_c();
    check_state(r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'h5eed));
    dev = {5'b01011, strap};
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_gpo = 2'b00; m_sd = 1'b0; m_sel = 1'b0;
    wt(5); rst_n = 1'b1; wt(10);
    check_state("R6 reset");
    chk("R6 SDA released", sda_oe, 0);

    wr(dev, 8'h00, 1, 1, "R4 ch1 single");
    wr(dev, 8'h80, 3, 1, "R4 ch2 repeated");
    rd(dev, 2, "R5 read ch2");
    wr(dev, 8'h00, 0, 0, "R5 select ch1");
    rd(dev, 1, "R5 repeated start read ch1");
    wr(dev, 8'h1F, 0, 1, "R8 R2 gpo only");
    wr(dev, 8'hC0, 0, 1, "R3 midscale ch2");
    rd(dev, 1, "R3 readback");
    wr(dev ^ 7'h01, 8'h58, 2, 1, "R1 mismatch");
    rd(dev ^ 7'h02, 1, "R1 read mismatch");

    shdn_n = 1'b0; wt(2); check_state("R7 pin shutdown");
    wr(dev, 8'h08, 1, 1, "R7 write in shutdown");
    shdn_n = 1'b1; wt(2); check_state("R7 pin release");
    wr(dev, 8'hA0, 0, 1, "R7 soft shutdown");
    wr(dev, 8'h90, 0, 1, "R7 soft release");

    start_c();
    put_byte({dev, 1'b0}, ack);
    chk("R9 abort address ack", ack, 1);
    put_bits(8'hFF, 4);
    stop_c();
    chk("R9 released after abort", sda_bus, 1);
    check_state("R9 partial byte ignored");
    wr(dev, 8'h08, 1, 1, "R9 recovery");

    for (int it = 0; it < 30; it++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 3);
      a = ($urandom % 6 == 0) ? dev ^ 7'(1 + $urandom % 3) : dev;
      if (op == 0)      wr(a, 8'($urandom), int'($urandom % 4), 1, "R4 random write");
      else if (op == 1) rd(a, 1 + int'($urandom % 3), "R5 random read");
      else begin
        shdn_n = ~shdn_n; wt(2); check_state("R7 random shutdown");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule